// File: doc/BRIEF.md
# Bidirectional Common Row Scanner

This block drives the row (common) side of a dot-matrix liquid crystal panel with 240 rows. A single select token enters a 240-stage register from the frame-start input and moves one stage each time the line clock falls. For every channel, the block then produces a 2-bit code that picks one of four drive levels. The code depends on whether the row currently holds the token and on the polarity of the alternation input. The analog level switches that follow the code are outside the block.

A direction input reverses the scan. A duty input splits the register into two independent 120-stage halves (channels 1..120 and 121..240) that are scanned at the same time, so a panel with half the line count can be driven. A blanking input forces every channel to its deselected level and leaves the scan position untouched.

The line clock is sampled in the `clk` domain by a two-state machine. Its state `LC_LOW` moves to `LC_HIGH` on transition `see_high` when `line_clk` is read as 1. `LC_HIGH` moves back to `LC_LOW` on transition `see_fall` when `line_clk` is read as 0, and that transition issues the one-cycle shift strike. The scan mode is decoded into four named modes: `SCAN_FWD_FULL`, `SCAN_REV_FULL`, `SCAN_FWD_SPLIT` and `SCAN_REV_SPLIT`.

Top module: `cscan_top`

## Requirements
- R1: While `rst_n` is low, every register stage is cleared, so no channel is selected and all channels show the deselected code for the current `alt_m`.
- R2: The register changes only at the first rising `clk` edge that samples `line_clk` low after it was sampled high. Holding `line_clk` high or low, or raising it, leaves all outputs unchanged.
- R3: With `duty_half`=0 and `scan_rev`=0, each shift loads `frame_mark` into channel 1 and moves the contents of channel k to channel k+1. The old contents of channel 240 are dropped.
- R4: With `duty_half`=0 and `scan_rev`=1, each shift loads `frame_mark` into channel 240 and moves the contents of channel k to channel k-1. The old contents of channel 1 are dropped.
- R5: With `duty_half`=1 and `scan_rev`=0, each shift loads `frame_mark` into both channel 1 and channel 121. Each half shifts upward, and the contents of channel 120 do not pass into channel 121.
- R6: With `duty_half`=1 and `scan_rev`=1, each shift loads `frame_mark` into both channel 120 and channel 240. Each half shifts downward, and the contents of channel 121 do not pass into channel 120.
- R7: The code of channel n is `level_o[2n-1:2n-2]`. The codes are: selected with `alt_m`=1 gives 2'b00 (V1); selected with `alt_m`=0 gives 2'b11 (V6); deselected with `alt_m`=1 gives 2'b10 (V5); deselected with `alt_m`=0 gives 2'b01 (V2). The output follows `alt_m` without waiting for a clock.
- R8: While `blank`=1, every channel shows the deselected code for the current `alt_m`. Shifting continues, and the true scan position reappears once `blank` returns to 0.
- R9: `frame_mark` is taken at each shift. Holding it high across several shifts loads a run of adjacent selected channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk | input | 1 | Line clock; its falling edge advances the scan |
| frame_mark | input | 1 | Frame start; value loaded into the entry stage(s) |
| alt_m | input | 1 | Drive polarity (alternation) input |
| scan_rev | input | 1 | 0: scan 1 toward 240; 1: scan 240 toward 1 |
| duty_half | input | 1 | 1: two 120-stage halves scanned in parallel |
| blank | input | 1 | Display-off; forces deselected codes |
| level_o | output | 480 | 2-bit drive code per channel, channel 1 in bits 1:0 |

## Verification
A single token is walked through every stage in each of the four scan modes, and then one shift past the end. This separates correct entry points, the split boundary between channels 120 and 121, and the loss of the token at the exit. A run of adjacent tokens, loaded by holding `frame_mark` high, shows that the input is taken at each shift and not only once. Toggling `alt_m` and `blank` between shifts separates the four code values and shows that blanking hides the scan position without altering it. A seeded random sequence then mixes the modes, mid-scan direction and duty changes, polarity and blanking, and compares every output against a bench model of the register.

// File: rtl/cscan_pkg.sv
package cscan_pkg;

    // Drive level codes for one channel
    typedef enum logic [1:0] {
        LVL_V1 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V5 = 2'b10,
        LVL_V6 = 2'b11
    } lvl_e;

    // Scan modes, decoded from direction and duty inputs
    typedef enum logic [1:0] {
        SCAN_FWD_FULL  = 2'd0,
        SCAN_REV_FULL  = 2'd1,
        SCAN_FWD_SPLIT = 2'd2,
        SCAN_REV_SPLIT = 2'd3
    } scan_e;

    // Line clock tracking states
    typedef enum logic {
        LC_LOW  = 1'b0,
        LC_HIGH = 1'b1
    } lc_state_e;

endpackage

// File: rtl/cscan_edge.sv
module cscan_edge
    import cscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    output logic step
);

    lc_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LC_LOW:  if (line_clk)  state_d = LC_HIGH;   // see_high
            LC_HIGH: if (!line_clk) state_d = LC_LOW;    // see_fall
            default: state_d = LC_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LC_LOW;
        else        state_q <= state_d;
    end

    // outputs: strike on the see_fall transition
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            LC_LOW:  step = 1'b0;
            LC_HIGH: step = !line_clk;
            default: step = 1'b0;
        endcase
    end

    // R2
    no_double_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

endmodule

// File: rtl/cscan_shift.sv
module cscan_shift
    import cscan_pkg::*;
#(
    parameter int CH = 240
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic          scan_rev,
    input  logic          duty_half,
    output logic [CH-1:0] sel_q
);

    localparam int HALF = CH / 2;

    scan_e         mode;
    logic [CH-1:0] up_n;
    logic [CH-1:0] down_n;
    logic [CH-1:0] nxt;

    always_comb begin
        unique case ({duty_half, scan_rev})
            2'b00:   mode = SCAN_FWD_FULL;
            2'b01:   mode = SCAN_REV_FULL;
            2'b10:   mode = SCAN_FWD_SPLIT;
            default: mode = SCAN_REV_SPLIT;
        endcase
    end

    assign up_n   = {sel_q[CH-2:0], load};
    assign down_n = {load, sel_q[CH-1:1]};

    always_comb begin
        nxt = up_n;
        unique case (mode)
            SCAN_FWD_FULL:  nxt = up_n;
            SCAN_REV_FULL:  nxt = down_n;
            SCAN_FWD_SPLIT: begin
                nxt       = up_n;
                nxt[HALF] = load;
            end
            SCAN_REV_SPLIT: begin
                nxt         = down_n;
                nxt[HALF-1] = load;
            end
            default: nxt = up_n;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sel_q <= '0;
        else if (step) sel_q <= nxt;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sel_q == '0));

    // R2
    hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sel_q));

    // R3
    fwd_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !scan_rev && !duty_half) |=>
            (sel_q[0] == $past(load)) && (sel_q[CH-1:1] == $past(sel_q[CH-2:0])));

    // R4
    rev_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && scan_rev && !duty_half) |=>
            (sel_q[CH-1] == $past(load)) && (sel_q[CH-2:0] == $past(sel_q[CH-1:1])));

    // R5
    fwd_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !scan_rev && duty_half) |=>
            (sel_q[0] == $past(load)) && (sel_q[HALF] == $past(load)));

    // R6
    rev_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && scan_rev && duty_half) |=>
            (sel_q[HALF-1] == $past(load)) && (sel_q[CH-1] == $past(load)));

endmodule

// File: rtl/cscan_level.sv
module cscan_level
    import cscan_pkg::*;
#(
    parameter int CH = 240
) (
    input  logic [CH-1:0]   sel,
    input  logic            alt_m,
    input  logic            blank,
    output logic [2*CH-1:0] level_o
);

    for (genvar i = 0; i < CH; i++) begin : g_ch
        lvl_e code;
        always_comb begin
            unique case ({sel[i] & ~blank, alt_m})
                2'b11:   code = LVL_V1;
                2'b10:   code = LVL_V6;
                2'b01:   code = LVL_V5;
                default: code = LVL_V2;
            endcase
        end
        assign level_o[2*i +: 2] = code;
    end

endmodule

// File: rtl/cscan_top.sv
module cscan_top
    import cscan_pkg::*;
#(
    parameter int CH = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_clk,
    input  logic            frame_mark,
    input  logic            alt_m,
    input  logic            scan_rev,
    input  logic            duty_half,
    input  logic            blank,
    output logic [2*CH-1:0] level_o
);

    logic          step;
    logic [CH-1:0] sel_q;

    cscan_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_clk (line_clk),
        .step     (step)
    );

    cscan_shift #(.CH(CH)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .load      (frame_mark),
        .scan_rev  (scan_rev),
        .duty_half (duty_half),
        .sel_q     (sel_q)
    );

    cscan_level #(.CH(CH)) u_level (
        .sel     (sel_q),
        .alt_m   (alt_m),
        .blank   (blank),
        .level_o (level_o)
    );

    for (genvar i = 0; i < CH; i++) begin : g_chk
        // R8
        blank_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            blank |-> (level_o[2*i+1] != level_o[2*i]));
    end

endmodule

// File: tb/cscan_top_test.sv
module cscan_top_test;

    localparam int CH   = 240;
    localparam int HALF = CH / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            line_clk = 1'b0;
    logic            frame_mark = 1'b0;
    logic            alt_m = 1'b1;
    logic            scan_rev = 1'b0;
    logic            duty_half = 1'b0;
    logic            blank = 1'b0;
    logic [2*CH-1:0] level_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  model [CH];

    always #4 clk = ~clk;

    cscan_top #(.CH(CH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_clk   (line_clk),
        .frame_mark (frame_mark),
        .alt_m      (alt_m),
        .scan_rev   (scan_rev),
        .duty_half  (duty_half),
        .blank      (blank),
        .level_o    (level_o)
    );

    // R7 code table
    function automatic logic [1:0] code_of(bit s, bit m, bit off);
        bit e = s && !off;
        if (e)  return m ? 2'b00 : 2'b11;
        return m ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [2*CH-1:0] expected();
        logic [2*CH-1:0] v;
        for (int k = 0; k < CH; k++) v[2*k +: 2] = code_of(model[k], alt_m, blank);
        return v;
    endfunction

    task automatic model_shift(bit f);
        if (!scan_rev) begin
            for (int k = CH-1; k > 0; k--) model[k] = model[k-1];
            model[0] = f;
            if (duty_half) model[HALF] = f;
        end else begin
            for (int k = 0; k < CH-1; k++) model[k] = model[k+1];
            model[CH-1] = f;
            if (duty_half) model[HALF-1] = f;
        end
    endtask

    task automatic check(string rq);
        logic [2*CH-1:0] e;
        e = expected();
        n_chk++;
        if (level_o !== e) begin
            n_fail++;
            $display("FAIL %s: level_o=%h expected=%h", rq, level_o, e);
        end
    endtask

    task automatic do_step(bit f, string rq);
        @(negedge clk); line_clk = 1'b1;
        @(negedge clk); line_clk = 1'b0; frame_mark = f;
        @(negedge clk);
        model_shift(f);
        check(rq);
    endtask

    task automatic clear_model();
        for (int k = 0; k < CH; k++) model[k] = 1'b0;
    endtask

    task automatic flush(int n, string rq);
        for (int k = 0; k < n; k++) do_step(1'b0, rq);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_model();
        // R1: reset state under both polarities
        repeat (3) @(negedge clk);
        check("R1");
        alt_m = 1'b0; #1; check("R1");
        alt_m = 1'b1;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); check("R1");

        // R2: rise and hold do nothing; only the fall shifts
        do_step(1'b1, "R3");
        @(negedge clk); line_clk = 1'b1;
        repeat (5) @(negedge clk);
        check("R2");
        frame_mark = 1'b1;
        repeat (3) @(negedge clk);
        check("R2");
        line_clk = 1'b0; frame_mark = 1'b0;
        @(negedge clk); model_shift(1'b0); check("R2");
        repeat (4) @(negedge clk); check("R2");

        // R3: token walks 1 -> 240 then drops out
        flush(CH, "R3");
        clear_model();
        do_step(1'b1, "R3");
        for (int k = 0; k < CH; k++) do_step(1'b0, "R3");

        // R4: reverse full walk
        scan_rev = 1'b1;
        do_step(1'b1, "R4");
        for (int k = 0; k < CH; k++) do_step(1'b0, "R4");

        // R5: split forward, boundary 120/121
        scan_rev = 1'b0; duty_half = 1'b1;
        do_step(1'b1, "R5");
        for (int k = 0; k < HALF; k++) do_step(1'b0, "R5");

        // R6: split reverse
        scan_rev = 1'b1;
        do_step(1'b1, "R6");
        for (int k = 0; k < HALF; k++) do_step(1'b0, "R6");

        // R9: run of tokens from held frame_mark
        scan_rev = 1'b0; duty_half = 1'b0;
        for (int k = 0; k < 4; k++) do_step(1'b1, "R9");
        for (int k = 0; k < 3; k++) do_step(1'b0, "R9");

        // R7: all four codes
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); alt_m = ~alt_m; #1; check("R7");
        end

        // R8: blanking hides but does not disturb the scan
        @(negedge clk); blank = 1'b1; #1; check("R8");
        alt_m = 1'b0; #1; check("R8");
        do_step(1'b1, "R8");
        do_step(1'b0, "R8");
        @(negedge clk); blank = 1'b0; #1; check("R8");
        alt_m = 1'b1; #1; check("R8");

        // random mix, fixed seed
        void'($urandom(32'h5eed_c0de));
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if ($urandom_range(7) == 0) scan_rev  = $urandom_range(1);
            if ($urandom_range(7) == 0) duty_half = $urandom_range(1);
            alt_m = $urandom_range(1);
            blank = ($urandom_range(7) == 0);
            do_step($urandom_range(9) == 0, duty_half ? (scan_rev ? "R6" : "R5")
                                                      : (scan_rev ? "R4" : "R3"));
        end

        // R1: reset mid-scan clears everything
        @(negedge clk); blank = 1'b0; rst_n = 1'b0; clear_model(); #1; check("R1");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); check("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule